// File: doc/BRIEF.md
# Two-Channel IDE Bus-Master DMA Register Bank

This block holds the host-visible control state of a two-channel IDE bus-master DMA function. The host reaches it through a plain byte port: an address, a write strobe with write data, and combinational read data. Each channel owns an eight-byte window with these registers: a command byte, a view of a mode byte that both channels share, a status byte, a timing byte and a four-byte descriptor-table pointer. The data mover, the drive task files and configuration-space decoding are all outside this block.

Each drive channel supplies a level interrupt request and an error flag. The bank records each request as a pending bit in the shared mode byte. Software can block each channel with its own mask bit in that byte. The single level-sensitive interrupt output is high when at least one channel has a pending request that is not blocked. The status byte combines a transfer-active bit controlled by the command byte, sticky event bits that software clears by writing ones, and two plain scratch bits. A synchronous active-low reset clears everything, which also cancels any active transfer.

Top module: `ide_dma_regbank`

## Requirements
- R1: Offsets 0-7 address channel 0 and offsets 8-15 address channel 1. Within a window, byte 0 is the command byte, byte 1 is the mode byte, byte 2 is the status byte, byte 3 is the timing byte, and bytes 4-7 are the pointer bytes, least significant byte first. Every pointer byte can be written and read back independently for each channel.
- R2: Offsets 16 and above read as 0xFF, and writes to them change no register.
- R3: Byte 1 reads the same shared mode byte from both windows. Bit 2 is the channel 0 pending flag, bit 3 is the channel 1 pending flag, bit 4 blocks channel 0 and bit 5 blocks channel 1. A host write updates only bits 4 and 5. Bits 0, 1, 6 and 7 read as 0.
- R4: The interrupt output equals (pending0 AND NOT block0) OR (pending1 AND NOT block1). It follows a mode write in the cycle after the write edge.
- R5: Each pending bit equals the channel's interrupt input as sampled at the previous clock edge, so it is set and cleared with the input.
- R6: A status write loads bits 5 and 6 from the data, leaves bit 0 unchanged, clears bits 1 and 2 where the data holds a 1, and keeps them where it holds a 0. Bits 3, 4 and 7 always read 0.
- R7: Status bit 2 is set in every cycle in which the channel's interrupt input is high, and status bit 1 is set in every cycle in which its error input is high. A set in the same cycle as a write-one-to-clear wins over the clear.
- R8: The command byte reads back exactly as written. Writing it with bit 0 at 1 sets status bit 0, and writing it with bit 0 at 0 clears status bit 0.
- R9: Each channel has its own timing byte. A write to byte 3 replaces that byte in full and does not touch the other channel's timing byte.
- R10: While reset is low, every register clears to 0 on the clock edge, which includes status bit 0 of both channels, and the interrupt output stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| we | input | 1 | Byte write strobe |
| addr | input | ADDR_W | Byte offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| chan_irq | input | 2 | Interrupt request level for each drive channel |
| chan_err | input | 2 | Error flag for each drive channel |
| irq_o | output | 1 | Combined level interrupt |

## Verification
A wrong pending or block bit shows up on `irq_o` one cycle after the input change or the mode write that caused it, and it also appears on a read of byte 1 from either window. A status bit that was cleared or kept wrongly stays visible on the next read of byte 2, because the event bits are sticky. Crossed channel decoding, for example a timing or pointer write that lands in the other window, is exposed by reading back both channels after writing different values to each.

// File: rtl/ide_dma_regbank.sv
module ide_dma_regbank #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [1:0]        chan_irq,
  input  logic [1:0]        chan_err,
  output logic              irq_o
);
  localparam int NCH = 2;

  logic [2:0] off;
  logic       in_range;
  logic [1:0] pend, blk;
  logic [7:0] mode;
  logic [7:0] chan_rd [NCH];
  logic [7:0] chan_st [NCH];

  assign off      = addr[2:0];
  assign in_range = (addr >> 4) == '0;
  assign mode     = {2'b00, blk, pend, 2'b00};
  assign irq_o    = (pend[0] & ~blk[0]) | (pend[1] & ~blk[1]);
  assign rdata    = in_range ? chan_rd[addr[3]] : 8'hFF;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      blk  <= '0;
    end else begin
      pend <= chan_irq;
      if (we && in_range && off == 3'd1) blk <= wdata[5:4];
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic       wsel;
    logic [7:0] cmd, tim;
    logic [7:0] ptr [4];
    logic       act, ev_err, ev_irq;
    logic [1:0] scratch;

    assign wsel       = we && in_range && (addr[3] == 1'(c));
    assign chan_st[c] = {1'b0, scratch, 2'b00, ev_irq, ev_err, act};

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cmd     <= '0;
        tim     <= '0;
        act     <= 1'b0;
        ev_err  <= 1'b0;
        ev_irq  <= 1'b0;
        scratch <= '0;
        for (int i = 0; i < 4; i++) ptr[i] <= '0;
      end else begin
        if (wsel && off == 3'd0) begin
          cmd <= wdata;
          act <= wdata[0];
        end
        if (wsel && off == 3'd2) scratch <= wdata[6:5];
        if (wsel && off == 3'd3) tim <= wdata;
        if (wsel && off[2]) ptr[off[1:0]] <= wdata;
        if (chan_err[c]) ev_err <= 1'b1;
        else if (wsel && off == 3'd2 && wdata[1]) ev_err <= 1'b0;
        if (chan_irq[c]) ev_irq <= 1'b1;
        else if (wsel && off == 3'd2 && wdata[2]) ev_irq <= 1'b0;
      end
    end

    always_comb begin
      case (off)
        3'd0:    chan_rd[c] = cmd;
        3'd1:    chan_rd[c] = mode;
        3'd2:    chan_rd[c] = chan_st[c];
        3'd3:    chan_rd[c] = tim;
        default: chan_rd[c] = ptr[off[1:0]];
      endcase
    end
  end
endmodule

// File: rtl/ide_dma_regbank_chk.sv
module ide_dma_regbank_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic [7:0]        rdata,
  input logic [1:0]        chan_irq,
  input logic              irq_o,
  input logic [7:0]        st0,
  input logic [7:0]        st1
);
  logic ch0_stat_wr, ch1_stat_wr, ch0_cmd_wr, mode_wr;
  assign ch0_stat_wr = we && addr == ADDR_W'(2);
  assign ch1_stat_wr = we && addr == ADDR_W'(10);
  assign ch0_cmd_wr  = we && addr == ADDR_W'(0);
  assign mode_wr     = we && (addr == ADDR_W'(1) || addr == ADDR_W'(9));

  p_unmapped_ff_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((addr >> 4) != '0) |-> rdata == 8'hFF);

  p_irq_needs_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(|chan_irq));

  p_block_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && wdata[5:4] == 2'b11) |=> !irq_o);

  p_w1c_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ch0_stat_wr && wdata[2] && !chan_irq[0]) |=> !st0[2]);

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    chan_irq[1] |=> st1[2]);

  p_scratch_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ch1_stat_wr |=> st1[6:5] == $past(wdata[6:5]));

  p_cmd_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ch0_cmd_wr |=> st0[0] == $past(wdata[0]));
endmodule

bind ide_dma_regbank ide_dma_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
  .rdata(rdata), .chan_irq(chan_irq), .irq_o(irq_o),
  .st0(chan_st[0]), .st1(chan_st[1])
);

// File: tb/tb_ide_dma_regbank.sv
`timescale 1ns/1ps
module tb_ide_dma_regbank;
  localparam int ADDR_W = 5;
  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0, irq_o;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [1:0] chan_irq = '0, chan_err = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ide_dma_regbank #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .chan_irq(chan_irq), .chan_err(chan_err), .irq_o(irq_o));

  // {req, op(0=write,1=read), addr, data, expected}
  localparam int NV = 34;
  localparam logic [39:0] VEC [NV] = '{
    {8'd9, 8'd0, 8'h03, 8'hA5, 8'h00}, {8'd9, 8'd0, 8'h0B, 8'h5A, 8'h00},
    {8'd9, 8'd1, 8'h03, 8'h00, 8'hA5}, {8'd9, 8'd1, 8'h0B, 8'h00, 8'h5A}, // R9
    {8'd1, 8'd0, 8'h04, 8'h11, 8'h00}, {8'd1, 8'd0, 8'h05, 8'h22, 8'h00},
    {8'd1, 8'd0, 8'h06, 8'h33, 8'h00}, {8'd1, 8'd0, 8'h07, 8'h44, 8'h00},
    {8'd1, 8'd0, 8'h0C, 8'h99, 8'h00}, {8'd1, 8'd1, 8'h07, 8'h00, 8'h44},
    {8'd1, 8'd1, 8'h05, 8'h00, 8'h22}, {8'd1, 8'd1, 8'h0C, 8'h00, 8'h99},
    {8'd1, 8'd1, 8'h04, 8'h00, 8'h11}, {8'd1, 8'd1, 8'h0D, 8'h00, 8'h00}, // R1
    {8'd8, 8'd0, 8'h00, 8'h81, 8'h00}, {8'd8, 8'd1, 8'h00, 8'h00, 8'h81},
    {8'd8, 8'd1, 8'h02, 8'h00, 8'h01}, {8'd8, 8'd1, 8'h0A, 8'h00, 8'h00},
    {8'd8, 8'd0, 8'h00, 8'h80, 8'h00}, {8'd8, 8'd1, 8'h02, 8'h00, 8'h00}, // R8
    {8'd6, 8'd0, 8'h02, 8'hFF, 8'h00}, {8'd6, 8'd1, 8'h02, 8'h00, 8'h60},
    {8'd6, 8'd0, 8'h00, 8'h01, 8'h00}, {8'd6, 8'd0, 8'h02, 8'h00, 8'h00},
    {8'd6, 8'd1, 8'h02, 8'h00, 8'h01},                                    // R6
    {8'd3, 8'd0, 8'h01, 8'hFF, 8'h00}, {8'd3, 8'd1, 8'h01, 8'h00, 8'h30},
    {8'd3, 8'd1, 8'h09, 8'h00, 8'h30}, {8'd3, 8'd0, 8'h09, 8'h10, 8'h00},
    {8'd3, 8'd1, 8'h01, 8'h00, 8'h10},                                    // R3
    {8'd2, 8'd0, 8'h14, 8'h77, 8'h00}, {8'd2, 8'd1, 8'h14, 8'h00, 8'hFF},
    {8'd2, 8'd1, 8'h1F, 8'h00, 8'hFF}, {8'd2, 8'd1, 8'h04, 8'h00, 8'h11}  // R2
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a[ADDR_W-1:0]; wdata = d;
    @(posedge clk); @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk); addr = a[ADDR_W-1:0]; #1;
    chk(tag, rdata, exp);
  endtask

  task automatic set_in(input logic [1:0] irq, input logic [1:0] err);
    @(negedge clk); chan_irq = irq; chan_err = err;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R10 reset state
    for (int a = 0; a < 16; a++) rd("R10 reset regs", 8'(a), 8'h00);
    chk("R10 irq after reset", {7'd0, irq_o}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][31:24] == 8'd0) wr(VEC[i][23:16], VEC[i][15:8]);
      else rd($sformatf("R%0d vector %0d", VEC[i][39:32], i), VEC[i][23:16], VEC[i][7:0]);
    end

    // mode = 0x10 (ch0 blocked), ch0 status = 0x01
    set_in(2'b01, 2'b00); @(negedge clk);
    chk("R4 blocked ch0 irq", {7'd0, irq_o}, 8'h00);
    rd("R5 pending0 set", 8'h01, 8'h14);
    rd("R7 ch0 status event", 8'h02, 8'h05);
    wr(8'h01, 8'h00);
    chk("R4 unblocked ch0 irq", {7'd0, irq_o}, 8'h01);
    // same-cycle set and clear: set wins
    wr(8'h02, 8'h04);
    rd("R7 set beats clear", 8'h02, 8'h05);
    set_in(2'b00, 2'b00); @(negedge clk);
    chk("R5 irq falls with input", {7'd0, irq_o}, 8'h00);
    rd("R5 pending0 cleared", 8'h09, 8'h00);
    rd("R6 sticky kept", 8'h02, 8'h05);
    wr(8'h02, 8'h04);
    rd("R6 w1c bit2", 8'h02, 8'h01);
    // channel 1 error and blocked interrupt
    set_in(2'b00, 2'b10); set_in(2'b00, 2'b00);
    rd("R7 ch1 error bit", 8'h0A, 8'h02);
    wr(8'h0A, 8'h02);
    rd("R6 w1c bit1", 8'h0A, 8'h00);
    wr(8'h09, 8'h20);
    set_in(2'b10, 2'b00); @(negedge clk);
    rd("R3 pending1 with block1", 8'h01, 8'h28);
    chk("R4 blocked ch1 irq", {7'd0, irq_o}, 8'h00);
    wr(8'h01, 8'h10);
    chk("R4 ch1 irq unblocked", {7'd0, irq_o}, 8'h01);
    // R10 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R10 irq low in reset", {7'd0, irq_o}, 8'h00);
    rd("R10 status cleared", 8'h02, 8'h00);
    rd("R10 timing cleared", 8'h0B, 8'h00);
    finish_run();
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end
endmodule